// File: doc/BRIEF.md
# Asynchronous static RAM access sequencer

This block lets a clocked host perform single-word reads and writes on an asynchronous 2048 x 8 static RAM. The host raises a request with a read/write select, address and write data. The sequencer then drives the RAM's active-low chip-enable, write-enable and output-enable lines through timed phases. Each phase length is a whole number of clock cycles, computed by ceiling division of a nanosecond limit by the clock period and never less than one cycle. On the data side the block drives an output value with a separate output-enable for the pad and samples the input value.

A write runs in three phases. Chip enable falls first, for the address setup. Write enable is then pulsed low while write data is driven. Chip enable stays low for a recovery stretch that completes the write cycle. A read holds chip enable and output enable low, with write enable high, long enough to cover the access time. The returned word is captured into a host register on the last clock of that window. Between accesses chip enable is high, which keeps the RAM in standby. After each write, the block stays busy for one extra cycle before it accepts the next request.

With default timing and a 4 ns clock, the phases are: address setup 1 cycle, write pulse 4, write recovery 1, read window 5.

Top module: `sram_async_ctrl`

## Requirements
- R1: After reset, and whenever busy_o is low, ram_ce_n_o, ram_we_n_o and ram_oe_n_o are 1 and ram_dq_oe_o is 0; busy_o and done_o are 0 out of reset.
- R2: A request (req_i high at a clock edge while busy_o is low) is accepted at that edge and busy_o rises. A request held high while busy_o is high is not lost: it is accepted on the first edge where busy_o is low and executes with its own address and data.
- R3: In a write, ram_ce_n_o goes low exactly one cycle before ram_we_n_o falls. ram_we_n_o is low only while ram_ce_n_o is low. ram_addr_o does not change while ram_ce_n_o is low.
- R4: In a write, ram_we_n_o stays low for exactly 4 cycles. ram_dq_oe_o is 1 exactly while ram_we_n_o is 0. ram_dq_o equals the request's write data and stays stable during that time.
- R5: A write keeps ram_ce_n_o low for 6 cycles in total. The RAM location at the request address then holds the write data.
- R6: A read holds ram_ce_n_o and ram_oe_n_o low together for exactly 5 cycles, with ram_we_n_o high. rdata_o then equals the word the RAM presents on ram_dq_i at the last of those cycles.
- R7: Each access produces exactly one done_o pulse, one cycle long. It occurs in the first cycle in which ram_ce_n_o is high again.
- R8: When a request is already pending, chip enable stays high for 2 cycles between the end of a write and the next access, and for 1 cycle between the end of a read and the next access.
- R9: rdata_o changes only at the end of a read; writes leave it unchanged.
- R10: The controller never drives the data bus while the RAM may drive it: ram_dq_oe_o is never 1 while ram_oe_n_o is 0, and ram_oe_n_o and ram_we_n_o are never low together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_i | input | 1 | Access request, held until accepted |
| wr_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | 11 | Word address |
| wdata_i | input | 8 | Write data |
| busy_o | output | 1 | Sequencer occupied; request not accepted |
| done_o | output | 1 | One-cycle completion pulse |
| rdata_o | output | 8 | Last word read |
| ram_ce_n_o | output | 1 | RAM chip enable, active low |
| ram_we_n_o | output | 1 | RAM write enable, active low |
| ram_oe_n_o | output | 1 | RAM output enable, active low |
| ram_addr_o | output | 11 | RAM address |
| ram_dq_o | output | 8 | Data driven toward the RAM |
| ram_dq_i | input | 8 | Data received from the RAM |
| ram_dq_oe_o | output | 1 | Pad drive enable for ram_dq_o |

## Verification
A wrong state or a miscounted phase timer shows up at the pins within one access, as a chip-enable, write-pulse or output-enable window of the wrong length. The bench measures these windows cycle by cycle on every access. A bad data-drive decode shows up as bus contention or a missed RAM update. The bench flags contention in the cycle it happens and finds a missed update on the next read-back. A lost or duplicated request shows up as a missing or extra done pulse, or as wrong read data. The pending-request cases expose a wrong turnaround gap within two cycles.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WSETUP,
    ST_WPULSE,
    ST_WRECOV,
    ST_GAP,
    ST_RACC
  } sram_st_e;

  function automatic int ceil_div(input int num, input int den);
    return (num + den - 1) / den;
  endfunction

  function automatic int at_least_one(input int v);
    return (v < 1) ? 1 : v;
  endfunction

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
module sram_phase_timer #(
  parameter int CNT_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] len_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cnt_q <= '0;
    else if (load_i)        cnt_q <= len_i;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/sram_rd_capture.sv
module sram_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cap_i,
  input  logic [DW-1:0] d_i,
  output logic [DW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    q_o <= '0;
    else if (cap_i) q_o <= d_i;
  end
endmodule

// File: rtl/sram_seq_fsm.sv
module sram_seq_fsm
  import sram_ctrl_pkg::*;
#(
  parameter int AW        = 11,
  parameter int DW        = 8,
  parameter int CNT_W     = 3,
  parameter int SETUP_CYC = 1,
  parameter int PULSE_CYC = 4,
  parameter int REC_CYC   = 1,
  parameter int RD_CYC    = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             wr_i,
  input  logic [AW-1:0]    addr_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic [CNT_W-1:0] len_o,
  output logic             cap_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             ram_ce_n_o,
  output logic             ram_we_n_o,
  output logic             ram_oe_n_o,
  output logic [AW-1:0]    ram_addr_o,
  output logic [DW-1:0]    ram_dq_o,
  output logic             ram_dq_oe_o
);
  localparam logic [CNT_W-1:0] SETUP_L = CNT_W'(SETUP_CYC - 1);
  localparam logic [CNT_W-1:0] PULSE_L = CNT_W'(PULSE_CYC - 1);
  localparam logic [CNT_W-1:0] REC_L   = CNT_W'(REC_CYC - 1);
  localparam logic [CNT_W-1:0] RD_L    = CNT_W'(RD_CYC - 1);

  sram_st_e st_q, st_d;
  logic     accept;

  assign accept = (st_q == ST_IDLE) && req_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (req_i)  st_d = wr_i ? ST_WSETUP : ST_RACC;
      ST_WSETUP: if (zero_i) st_d = ST_WPULSE;
      ST_WPULSE: if (zero_i) st_d = ST_WRECOV;
      ST_WRECOV: if (zero_i) st_d = ST_GAP;
      ST_GAP:                st_d = ST_IDLE;   // write-to-next recovery cycle
      ST_RACC:   if (zero_i) st_d = ST_IDLE;
      default:               st_d = ST_IDLE;
    endcase
  end

  always_comb begin
    unique case (st_d)
      ST_WSETUP: len_o = SETUP_L;
      ST_WPULSE: len_o = PULSE_L;
      ST_WRECOV: len_o = REC_L;
      ST_RACC:   len_o = RD_L;
      default:   len_o = '0;
    endcase
  end

  assign load_o = (st_d != st_q);
  assign cap_o  = (st_q == ST_RACC) && zero_i;
  assign busy_o = (st_q != ST_IDLE);

  // Strobes registered from next state so the RAM sees glitch-free edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ram_ce_n_o  <= 1'b1;
      ram_we_n_o  <= 1'b1;
      ram_oe_n_o  <= 1'b1;
      ram_dq_oe_o <= 1'b0;
      done_o      <= 1'b0;
      ram_addr_o  <= '0;
      ram_dq_o    <= '0;
    end else begin
      st_q        <= st_d;
      ram_ce_n_o  <= !(st_d inside {ST_WSETUP, ST_WPULSE, ST_WRECOV, ST_RACC});
      ram_we_n_o  <= (st_d != ST_WPULSE);
      ram_oe_n_o  <= (st_d != ST_RACC);
      ram_dq_oe_o <= (st_d == ST_WPULSE);
      done_o      <= ((st_q == ST_WRECOV) || (st_q == ST_RACC)) && zero_i;
      if (accept) begin
        ram_addr_o <= addr_i;
        ram_dq_o   <= wdata_i;
      end
    end
  end

  assert_idle_standby_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (ram_ce_n_o && ram_we_n_o && ram_oe_n_o && !ram_dq_oe_o));
  assert_we_inside_ce_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_n_o |-> !ram_ce_n_o);
  assert_addr_setup_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ram_we_n_o) |-> $past(!ram_ce_n_o));
  assert_addr_stable_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_ce_n_o && $past(!ram_ce_n_o)) |-> $stable(ram_addr_o));
  assert_drive_in_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> !ram_we_n_o);
  assert_wdata_stable_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ram_dq_oe_o && $past(ram_dq_oe_o)) |-> $stable(ram_dq_o));
  assert_done_single_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  assert_done_deselected_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> ram_ce_n_o);
  assert_no_contention_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ram_dq_oe_o && !ram_oe_n_o) && !(!ram_oe_n_o && !ram_we_n_o));
endmodule

// File: rtl/sram_async_ctrl.sv
module sram_async_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int AW       = 11,
  parameter int DW       = 8,
  parameter int CLK_NS   = 4,
  parameter int T_SA_NS  = 0,   // address setup to write start
  parameter int T_WP_NS  = 15,  // write pulse width
  parameter int T_SD_NS  = 10,  // data setup to write end
  parameter int T_AW_NS  = 15,  // address setup to write end
  parameter int T_WC_NS  = 20,  // write cycle
  parameter int T_RC_NS  = 20,  // read cycle
  parameter int T_AA_NS  = 20,  // address access
  parameter int T_DOE_NS = 10   // output enable to data
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_i,
  input  logic          wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] wdata_i,
  output logic          busy_o,
  output logic          done_o,
  output logic [DW-1:0] rdata_o,
  output logic          ram_ce_n_o,
  output logic          ram_we_n_o,
  output logic          ram_oe_n_o,
  output logic [AW-1:0] ram_addr_o,
  output logic [DW-1:0] ram_dq_o,
  input  logic [DW-1:0] ram_dq_i,
  output logic          ram_dq_oe_o
);
  localparam int SETUP_CYC = at_least_one(ceil_div(T_SA_NS, CLK_NS));
  localparam int PULSE_CYC = at_least_one(ceil_div(max2(max2(T_WP_NS, T_SD_NS), T_AW_NS), CLK_NS));
  localparam int WC_CYC    = ceil_div(T_WC_NS, CLK_NS);
  localparam int REC_CYC   = at_least_one(WC_CYC - SETUP_CYC - PULSE_CYC);
  localparam int RD_CYC    = at_least_one(ceil_div(max2(max2(T_RC_NS, T_AA_NS), T_DOE_NS), CLK_NS));
  localparam int MAX_CYC   = max2(max2(SETUP_CYC, PULSE_CYC), max2(REC_CYC, RD_CYC));
  localparam int CNT_W     = at_least_one($clog2(MAX_CYC));

  logic             load, zero, cap;
  logic [CNT_W-1:0] len;

  sram_seq_fsm #(
    .AW(AW), .DW(DW), .CNT_W(CNT_W),
    .SETUP_CYC(SETUP_CYC), .PULSE_CYC(PULSE_CYC),
    .REC_CYC(REC_CYC), .RD_CYC(RD_CYC)
  ) u_fsm (
    .clk_i, .rst_ni, .req_i, .wr_i, .addr_i, .wdata_i,
    .zero_i(zero), .load_o(load), .len_o(len), .cap_o(cap),
    .busy_o, .done_o, .ram_ce_n_o, .ram_we_n_o, .ram_oe_n_o,
    .ram_addr_o, .ram_dq_o, .ram_dq_oe_o
  );

  sram_phase_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i, .rst_ni, .load_i(load), .len_i(len), .zero_o(zero)
  );

  sram_rd_capture #(.DW(DW)) u_cap (
    .clk_i, .rst_ni, .cap_i(cap), .d_i(ram_dq_i), .q_o(rdata_o)
  );

  assert_rdata_only_on_read_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(ram_oe_n_o) && $past(rst_ni)) |-> $stable(rdata_o));
endmodule

// File: tb/sram_async_ctrl_bench.sv
module sram_async_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wr = 1'b0;
  logic [10:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic        busy, done, ce_n, we_n, oe_n, dq_oe;
  logic [7:0]  rdata, dq_o, dq_i;
  logic [10:0] ram_addr;

  int checks = 0, errors = 0;
  logic [7:0] mem [2048];

  // monitor state
  int ce_run = 0, we_run = 0, oe_run = 0, ce_hi_run = 0, done_run = 0;
  int last_ce = 0, last_we = 0, last_oe = 0, last_ce_hi = 0, last_done = 0;
  int we_lead = 0, done_cnt = 0, cont_err = 0, drive_err = 0, stab_err = 0;
  logic        prev_ce_n = 1'b1, prev_oe = 1'b0;
  logic [10:0] prev_addr = '0;
  logic [7:0]  prev_dq = '0;

  always #2 clk = ~clk;

  sram_async_ctrl u_sram_async_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_i(wr), .addr_i(addr),
    .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .ram_ce_n_o(ce_n), .ram_we_n_o(we_n), .ram_oe_n_o(oe_n),
    .ram_addr_o(ram_addr), .ram_dq_o(dq_o), .ram_dq_i(dq_i), .ram_dq_oe_o(dq_oe)
  );

  wire ram_drv = !ce_n && !oe_n && we_n;
  assign dq_i = ram_drv ? mem[ram_addr] : 8'h00;

  task automatic chk(input string rq, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    if (!ce_n && !we_n) mem[ram_addr] = dq_o;
    if (ram_drv && dq_oe) cont_err++;
    if (dq_oe != !we_n) drive_err++;
    if (!ce_n && !prev_ce_n && ram_addr != prev_addr) stab_err++;
    if (dq_oe && prev_oe && dq_o != prev_dq) stab_err++;
    if (!we_n) begin
      if (we_run == 0) we_lead = ce_run;
      we_run++;
    end else if (we_run != 0) begin last_we = we_run; we_run = 0; end
    if (!oe_n) oe_run++;
    else if (oe_run != 0) begin last_oe = oe_run; oe_run = 0; end
    if (!ce_n) begin
      ce_run++;
      if (ce_hi_run != 0) begin last_ce_hi = ce_hi_run; ce_hi_run = 0; end
    end else begin
      ce_hi_run++;
      if (ce_run != 0) begin last_ce = ce_run; ce_run = 0; end
    end
    if (done) begin done_run++; if (done_run == 1) done_cnt++; end
    else if (done_run != 0) begin last_done = done_run; done_run = 0; end
    prev_ce_n = ce_n; prev_addr = ram_addr; prev_oe = dq_oe; prev_dq = dq_o;
  end

  task automatic issue(input logic w, input logic [10:0] a, input logic [7:0] d);
    @(negedge clk);
    req = 1'b1; wr = w; addr = a; wdata = d;
    while (busy) @(negedge clk);
    @(negedge clk);
    req = 1'b0; addr = ~a; wdata = ~d;
  endtask

  task automatic wait_done;
    while (!done) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic t_reset;
    #1;
    chk("R1 ce_n", ce_n, 1); chk("R1 we_n", we_n, 1); chk("R1 oe_n", oe_n, 1);
    chk("R1 dq_oe", dq_oe, 0); chk("R1 busy", busy, 0); chk("R1 done", done, 0);
  endtask

  task automatic t_write(input logic [10:0] a, input logic [7:0] d);
    int dc;
    dc = done_cnt;
    issue(1'b1, a, d);
    wait_done();
    chk("R3 ce lead before we", we_lead, 1);
    chk("R4 we low cycles", last_we, 4);
    chk("R5 ce low cycles", last_ce, 6);
    chk("R5 stored word", mem[a], d);
    chk("R7 done count", done_cnt - dc, 1);
    chk("R7 done width", last_done, 1);
    chk("R1 idle ce_n", ce_n, 1);
  endtask

  task automatic t_read(input logic [10:0] a, input logic [7:0] e);
    issue(1'b0, a, 8'h00);
    wait_done();
    chk("R6 oe low cycles", last_oe, 5);
    chk("R6 ce low cycles", last_ce, 5);
    chk("R6 read data", rdata, e);
  endtask

  task automatic t_pending_after_write;
    issue(1'b1, 11'h055, 8'h6E);
    issue(1'b0, 11'h055, 8'h00);   // raised while busy
    wait_done();
    chk("R8 ce high gap after write", last_ce_hi, 2);
    chk("R2 pending read data", rdata, 8'h6E);
  endtask

  task automatic t_pending_after_read;
    mem[11'h200] = 8'h19;
    issue(1'b0, 11'h123, 8'h00);
    issue(1'b0, 11'h200, 8'h00);
    wait_done();
    chk("R8 ce high gap after read", last_ce_hi, 1);
    chk("R2 second read data", rdata, 8'h19);
  endtask

  task automatic t_rdata_hold;
    t_read(11'h123, 8'hA5);
    t_write(11'h300, 8'hC7);
    chk("R9 rdata unchanged by write", rdata, 8'hA5);
  endtask

  initial begin
    for (int i = 0; i < 2048; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_write(11'h123, 8'hA5);
    t_write(11'h7FF, 8'h3C);
    t_write(11'h000, 8'h81);
    t_read(11'h123, 8'hA5);
    t_read(11'h7FF, 8'h3C);
    t_read(11'h000, 8'h81);
    t_pending_after_write();
    t_pending_after_read();
    t_rdata_hold();
    chk("R10 bus contention", cont_err, 0);
    chk("R4 drive outside write pulse", drive_err, 0);
    chk("R3 address/data stability", stab_err, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R2 watchdog actual=hung expected=completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule